// File: doc/BRIEF.md
# Interrupt enable register bank

This block holds one forwarding-enable bit per interrupt ID for an interrupt distributor, packed 32 to a word. Software reaches the bits through a simple register port. Writing a one to a bit of a clear-enable word turns forwarding of that interrupt off, and a companion set-enable port turns bits back on. The enable state goes out to the forwarding logic as flat vectors. Turning a bit off only stops forwarding. The pending and active state of the interrupt is kept elsewhere and is not touched.

Word 0 holds the processor-private interrupts and has a separate copy for each processor. A non-secure access cannot see or change the bits of interrupts marked as protected, unless the security-disable control is set. After every write that clears at least one bit, a busy flag stays high for a fixed number of cycles. Software polls this flag to learn that the disable has reached the downstream logic.

Top module: `irq_enable_bank`

## Requirements
- R1: Clear-enable word n is at byte offset 0x180 + 4*n, for n from 0 to 31. Interrupt ID m is bit m mod 32 of word m div 32, and a read returns 1 for each enabled bit. An access to any other offset, or to an offset whose two low bits are not zero, reads as 0 and changes nothing.
- R2: On the register port, writing 1 to a bit clears that enable, and writing 0 leaves the bit unchanged.
- R3: On the set port, writing 1 to a bit of word `set_word` enables that interrupt, and writing 0 leaves the bit unchanged. If a set and a clear reach the same bit in the same cycle, the bit ends up 0. No enable bit turns on without a set-port write.
- R4: A read request gives `rd_valid` high, with `rd_data`, in the cycle that follows the request, and `rd_valid` is high at no other time.
- R5: A word with index NUM_WORDS or higher reads as 0 and ignores writes from both ports.
- R6: When `sec_dis` is 0, the bits whose `grp_secure` bit is 1 read as 0 for non-secure accesses (`ns` = 1), and non-secure clears and sets leave them unchanged. Secure accesses, and all accesses made while `sec_dis` is 1, reach every implemented bit.
- R7: Each processor number p below NUM_PE (at most 8) has its own copy of word 0. An access from p reads and changes only that copy. A word 0 access from a processor number of NUM_PE or higher reads as 0 and changes nothing.
- R8: A clearing write is a register-port write whose data, after the masking of R1, R5, R6 and R7, still has at least one bit set. After such a write, `rwp_busy` is high for exactly BUSY_CYCLES cycles, starting in the cycle after the write. Another clearing write during that time starts the count again. Set-port writes and writes with no effect do not raise `rwp_busy`.
- R9: After reset, every enable bit is 0 and `rwp_busy` is 0.
- R10: Bit 32*p + x of `fwd_en_banked` is bit x of processor p's copy of word 0. Bit m - 32 of `fwd_en_shared` is the enable of interrupt ID m, for m of 32 or more. Both show the result of a write in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data (1 = clear) |
| req_ns | input | 1 | Access is non-secure |
| req_pe | input | PE_W | Processor number of the access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| set_valid | input | 1 | Set-enable write strobe |
| set_word | input | 5 | Target word index for the set |
| set_wdata | input | 32 | Set data (1 = enable) |
| set_ns | input | 1 | Set write is non-secure |
| set_pe | input | PE_W | Processor number of the set write |
| sec_dis | input | 1 | Security-disable control |
| grp_secure | input | NUM_WORDS*32 | 1 = interrupt is protected from non-secure access |
| fwd_en_banked | output | NUM_PE*32 | Per-processor word 0 enables |
| fwd_en_shared | output | (NUM_WORDS-1)*32 | Enables for interrupt IDs 32 and up |
| rwp_busy | output | 1 | A clear is still in flight |

## Verification
The hardest case to reach is the combination of masks. One write can be cut down at the same time by the implemented-word limit, by the processor check for word 0 and by the security filter. A bad intersection would show only for one rare combination of word, processor, security flag and `sec_dis`. The bench therefore sweeps every combination over a small configuration. The sweep includes one unimplemented word and one processor number outside the bank. For each combination, the bench first refills the target word with a secure set. It then clears with a pattern derived from a counter and compares the read-back, both output vectors and the length of the busy pulse with an arithmetic model. The same-cycle race between set and clear, and a busy restart in the middle of the count, are then driven one at a time.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_WORDS = 32;
   localparam int MAX_PE    = 8;
   localparam int IDX_W     = 5;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [IDX_W-1:0]  widx_t;
endpackage

// File: rtl/irq_en_access.sv
module irq_en_access
   import irq_en_pkg::*;
#(
   parameter int NUM_WORDS = 4,
   parameter int NUM_PE    = 8,
   parameter int PE_W      = 4
) (
   input  widx_t                      word_idx,
   input  logic [PE_W-1:0]            pe,
   input  logic                       ns,
   input  logic                       sec_dis,
   input  logic [NUM_WORDS*WORD_W-1:0] grp_secure,
   output word_t                      mask
);
   word_t grp_w;
   logic  implemented;
   logic  pe_ok;

   always_comb begin
      grp_w = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (word_idx == w[IDX_W-1:0]) grp_w = grp_secure[w*WORD_W +: WORD_W];
      end
   end

   assign implemented = int'(word_idx) < NUM_WORDS;
   assign pe_ok       = (word_idx != '0) || (int'(pe) < NUM_PE);

   always_comb begin
      if (!implemented || !pe_ok) mask = '0;
      else if (ns && !sec_dis)    mask = ~grp_w;
      else                        mask = '1;
   end
endmodule

// File: rtl/irq_en_word.sv
module irq_en_word
   import irq_en_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  word_t set_bits,
   input  word_t clr_bits,
   output word_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_bits) & ~clr_bits;
   end
endmodule

// File: rtl/irq_en_busy.sv
module irq_en_busy #(
   parameter int BUSY_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

   logic [CNT_W-1:0] cnt;

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = cnt != '0;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
   import irq_en_pkg::*;
#(
   parameter int NUM_WORDS   = 4,
   parameter int NUM_PE      = 8,
   parameter int PE_W        = 4,
   parameter int ADDR_W      = 12,
   parameter int BUSY_CYCLES = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [WORD_W-1:0]             req_wdata,
   input  logic                          req_ns,
   input  logic [PE_W-1:0]               req_pe,
   output logic                          rd_valid,
   output logic [WORD_W-1:0]             rd_data,
   input  logic                          set_valid,
   input  logic [IDX_W-1:0]              set_word,
   input  logic [WORD_W-1:0]             set_wdata,
   input  logic                          set_ns,
   input  logic [PE_W-1:0]               set_pe,
   input  logic                          sec_dis,
   input  logic [NUM_WORDS*WORD_W-1:0]   grp_secure,
   output logic [NUM_PE*WORD_W-1:0]      fwd_en_banked,
   output logic [(NUM_WORDS-1)*WORD_W-1:0] fwd_en_shared,
   output logic                          rwp_busy
);
   localparam logic [ADDR_W-1:0] CLR_BASE = ADDR_W'(12'h180);

   generate
      if (NUM_WORDS < 2 || NUM_WORDS > MAX_WORDS) begin : g_bad_words
         $error("NUM_WORDS must lie in 2..32");
      end
      if (NUM_PE < 1 || NUM_PE > MAX_PE || NUM_PE > (1 << PE_W)) begin : g_bad_pe
         $error("NUM_PE must lie in 1..8 and fit in PE_W bits");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
   endgenerate

   logic  clr_hit;
   widx_t clr_idx;
   word_t req_mask, set_mask;
   word_t clr_eff, set_eff;
   logic  clr_any;

   assign clr_hit = req_valid && (req_addr[ADDR_W-1:7] == CLR_BASE[ADDR_W-1:7])
                    && (req_addr[1:0] == 2'b00);
   assign clr_idx = req_addr[6:2];

   irq_en_access #(.NUM_WORDS(NUM_WORDS), .NUM_PE(NUM_PE), .PE_W(PE_W)) u_req_acc (
      .word_idx(clr_idx), .pe(req_pe), .ns(req_ns), .sec_dis(sec_dis),
      .grp_secure(grp_secure), .mask(req_mask));

   irq_en_access #(.NUM_WORDS(NUM_WORDS), .NUM_PE(NUM_PE), .PE_W(PE_W)) u_set_acc (
      .word_idx(set_word), .pe(set_pe), .ns(set_ns), .sec_dis(sec_dis),
      .grp_secure(grp_secure), .mask(set_mask));

   assign clr_eff = (clr_hit && req_write) ? (req_wdata & req_mask) : '0;
   assign set_eff = set_valid ? (set_wdata & set_mask) : '0;
   assign clr_any = |clr_eff;

   word_t bank_q [NUM_PE];
   word_t shr_q  [NUM_WORDS];

   genvar gp, gw;
   generate
      for (gp = 0; gp < NUM_PE; gp++) begin : g_bank
         word_t c_bits, s_bits;
         assign c_bits = (clr_idx == '0 && req_pe == PE_W'(gp)) ? clr_eff : '0;
         assign s_bits = (set_word == '0 && set_pe == PE_W'(gp)) ? set_eff : '0;
         irq_en_word u_word (.clk(clk), .rst_n(rst_n), .set_bits(s_bits),
                             .clr_bits(c_bits), .q(bank_q[gp]));
         assign fwd_en_banked[gp*WORD_W +: WORD_W] = bank_q[gp];
      end
      assign shr_q[0] = '0;
      for (gw = 1; gw < NUM_WORDS; gw++) begin : g_shared
         word_t c_bits, s_bits;
         assign c_bits = (clr_idx == IDX_W'(gw)) ? clr_eff : '0;
         assign s_bits = (set_word == IDX_W'(gw)) ? set_eff : '0;
         irq_en_word u_word (.clk(clk), .rst_n(rst_n), .set_bits(s_bits),
                             .clr_bits(c_bits), .q(shr_q[gw]));
         assign fwd_en_shared[(gw-1)*WORD_W +: WORD_W] = shr_q[gw];
      end
   endgenerate

   word_t rd_word;
   always_comb begin
      rd_word = '0;
      if (clr_idx == '0) begin
         for (int p = 0; p < NUM_PE; p++)
            if (req_pe == PE_W'(p)) rd_word = bank_q[p];
      end else begin
         for (int w = 1; w < NUM_WORDS; w++)
            if (clr_idx == IDX_W'(w)) rd_word = shr_q[w];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         rd_data  <= (req_valid && !req_write && clr_hit) ? (rd_word & req_mask) : '0;
      end
   end

   irq_en_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(clr_any), .busy(rwp_busy));
endmodule

// File: rtl/irq_enable_bank_chk.sv
module irq_enable_bank_chk #(
   parameter int NUM_WORDS = 4,
   parameter int NUM_PE    = 8
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_valid,
   input logic                           req_write,
   input logic                           set_valid,
   input logic                           clr_hit,
   input logic [4:0]                     clr_idx,
   input logic                           clr_any,
   input logic                           rd_valid,
   input logic [31:0]                    rd_data,
   input logic [NUM_PE*32-1:0]           fwd_en_banked,
   input logic [(NUM_WORDS-1)*32-1:0]    fwd_en_shared,
   input logic                           rwp_busy
);
   assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   assert_rd_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));

   assert_off_map_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !clr_hit) |=> (rd_data == '0));

   assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && clr_hit && int'(clr_idx) >= NUM_WORDS) |=> (rd_data == '0));

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> rwp_busy);

   assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwp_busy) |-> $past(clr_any));

   assert_no_gain_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !set_valid |=> ((fwd_en_shared & ~$past(fwd_en_shared)) == '0));

   assert_no_gain_banked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !set_valid |=> ((fwd_en_banked & ~$past(fwd_en_banked)) == '0));
endmodule

bind irq_enable_bank irq_enable_bank_chk #(.NUM_WORDS(NUM_WORDS), .NUM_PE(NUM_PE)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .set_valid(set_valid), .clr_hit(clr_hit), .clr_idx(clr_idx), .clr_any(clr_any),
   .rd_valid(rd_valid), .rd_data(rd_data), .fwd_en_banked(fwd_en_banked),
   .fwd_en_shared(fwd_en_shared), .rwp_busy(rwp_busy));

// File: tb/irq_enable_bank_test.sv
module irq_enable_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW  = 3;
   localparam int NPE = 2;
   localparam int PW  = 4;
   localparam int BC  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_write = 0, req_ns = 0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [PW-1:0] req_pe = '0;
   logic rd_valid;
   logic [31:0] rd_data;
   logic set_valid = 0, set_ns = 0;
   logic [4:0] set_word = '0;
   logic [31:0] set_wdata = '0;
   logic [PW-1:0] set_pe = '0;
   logic sec_dis = 0;
   logic [NW*32-1:0] grp_secure;
   logic [NPE*32-1:0] fwd_en_banked;
   logic [(NW-1)*32-1:0] fwd_en_shared;
   logic rwp_busy;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_bank [NPE];
   logic [31:0] m_sh   [NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_enable_bank #(.NUM_WORDS(NW), .NUM_PE(NPE), .PE_W(PW), .ADDR_W(12),
                     .BUSY_CYCLES(BC)) uut (.*);

   function automatic logic [31:0] grp_word(int w);
      logic [31:0] g;
      for (int b = 0; b < 32; b++) g[b] = ((w*32 + b) % 3) == 1;
      return g;
   endfunction

   function automatic logic [31:0] acc_mask(int w, int pe, bit ns);
      if (w >= NW) return '0;
      if (w == 0 && pe >= NPE) return '0;
      if (ns && !sec_dis) return ~grp_word(w);
      return '1;
   endfunction

   function automatic logic [31:0] model_word(int w, int pe);
      if (w == 0) return (pe < NPE) ? m_bank[pe] : '0;
      if (w < NW) return m_sh[w];
      return '0;
   endfunction

   function automatic int addr_word(logic [11:0] a);
      if (a[11:7] == 5'd3 && a[1:0] == 2'b00) return int'(a[6:2]);
      return -1;
   endfunction

   task automatic model_apply(int w, int pe, logic [31:0] s, logic [31:0] c);
      if (w == 0 && pe < NPE) m_bank[pe] = (m_bank[pe] | s) & ~c;
      else if (w > 0 && w < NW) m_sh[w] = (m_sh[w] | s) & ~c;
   endtask

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_fwd(string req);
      for (int p = 0; p < NPE; p++)
         check(fwd_en_banked[p*32 +: 32] == m_bank[p], req, fwd_en_banked[p*32 +: 32], m_bank[p]);
      for (int w = 1; w < NW; w++)
         check(fwd_en_shared[(w-1)*32 +: 32] == m_sh[w], req, fwd_en_shared[(w-1)*32 +: 32], m_sh[w]);
   endtask

   // Returns the effective cleared bits; ends at the negedge after the write edge.
   task automatic bus_write(logic [11:0] a, int pe, bit ns, logic [31:0] d, output logic [31:0] eff);
      int w;
      w = addr_word(a);
      eff = (w < 0) ? '0 : (d & acc_mask(w, pe, ns));
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_pe = PW'(pe); req_ns = ns; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      if (w >= 0) model_apply(w, pe, '0, eff);
   endtask

   task automatic set_write(int w, int pe, bit ns, logic [31:0] d);
      @(negedge clk);
      set_valid = 1; set_word = 5'(w); set_pe = PW'(pe); set_ns = ns; set_wdata = d;
      @(negedge clk);
      set_valid = 0;
      model_apply(w, pe, d & acc_mask(w, pe, ns), '0);
   endtask

   task automatic bus_read(logic [11:0] a, int pe, bit ns, string req);
      int w;
      logic [31:0] exp;
      w = addr_word(a);
      exp = (w < 0) ? '0 : (model_word(w, pe) & acc_mask(w, pe, ns));
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_pe = PW'(pe); req_ns = ns;
      @(negedge clk);
      req_valid = 0;
      check(rd_valid == 1'b1, "R4", {31'd0, rd_valid}, 32'd1);
      check(rd_data == exp, req, rd_data, exp);
   endtask

   task automatic expect_busy_pulse(string req);
      for (int k = 0; k < BC; k++) begin
         check(rwp_busy == 1'b1, req, {31'd0, rwp_busy}, 32'd1);
         @(negedge clk);
      end
      check(rwp_busy == 1'b0, req, {31'd0, rwp_busy}, 32'd0);
   endtask

   task automatic idle();
      repeat (BC + 1) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] eff;
      int c;
      for (int w = 0; w < NW; w++) grp_secure[w*32 +: 32] = grp_word(w);
      for (int p = 0; p < NPE; p++) m_bank[p] = '0;
      for (int w = 0; w < NW; w++) m_sh[w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R9: reset state
      check(fwd_en_banked == '0, "R9", fwd_en_banked[31:0], '0);
      check(fwd_en_shared == '0, "R9", fwd_en_shared[31:0], '0);
      check(rwp_busy == 1'b0, "R9", {31'd0, rwp_busy}, '0);
      check(rd_valid == 1'b0, "R4", {31'd0, rd_valid}, '0);
      for (int w = 0; w < NW + 1; w++) bus_read(12'h180 + 12'(4*w), 0, 0, "R1");

      // Sweep word x processor x security x sec_dis
      c = 0;
      for (int w = 0; w < NW + 1; w++)
         for (int pe = 0; pe < NPE + 1; pe++)
            for (int ns = 0; ns < 2; ns++)
               for (int sd = 0; sd < 2; sd++) begin
                  logic [31:0] pat;
                  c++;
                  sec_dis = sd[0];
                  idle();
                  set_write(w, pe, 0, '1);
                  check(rwp_busy == 1'b0, "R8", {31'd0, rwp_busy}, '0);
                  check_fwd("R3");
                  bus_read(12'h180 + 12'(4*w), pe, ns[0], (w >= NW) ? "R5" : (w == 0 ? "R7" : "R6"));
                  pat = 32'h9E3779B9 ^ (32'(c) * 32'h01010101);
                  bus_write(12'h180 + 12'(4*w), pe, ns[0], pat, eff);
                  check_fwd("R10");
                  if (eff != '0) expect_busy_pulse("R8");
                  else check(rwp_busy == 1'b0, "R8", {31'd0, rwp_busy}, '0);
                  bus_read(12'h180 + 12'(4*w), pe, ns[0], "R2");
                  bus_read(12'h180 + 12'(4*w), pe, 0, "R6");
                  idle();
                  bus_write(12'h180 + 12'(4*w), pe, 0, '1, eff);
                  idle();
                  set_write(w, pe, ns[0], ~pat);
                  check_fwd("R6");
                  bus_read(12'h180 + 12'(4*w), pe, 0, "R3");
               end
      sec_dis = 0;

      // R7: copies of word 0 are independent
      idle();
      set_write(0, 0, 0, 32'h0000FFFF);
      set_write(0, 1, 0, 32'hFFFF0000);
      bus_write(12'h180, 1, 0, 32'h00FF00FF, eff);
      check_fwd("R7");
      bus_read(12'h180, 0, 0, "R7");
      bus_read(12'h180, 1, 0, "R7");

      // R3: same-cycle set and clear on word 1, clear wins
      idle();
      bus_write(12'h184, 0, 0, '1, eff);
      idle();
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 12'h184; req_pe = '0; req_ns = 0;
      req_wdata = 32'h0000FFFF;
      set_valid = 1; set_word = 5'd1; set_pe = '0; set_ns = 0; set_wdata = 32'h00FF00FF;
      @(negedge clk);
      req_valid = 0; req_write = 0; set_valid = 0;
      model_apply(1, 0, 32'h00FF00FF, 32'h0000FFFF);
      check(fwd_en_shared[31:0] == 32'h00FF0000, "R3", fwd_en_shared[31:0], 32'h00FF0000);
      check_fwd("R3");

      // R2: writing zero changes nothing and does not start busy
      idle();
      set_write(2, 0, 0, 32'hC3C3C3C3);
      bus_write(12'h188, 0, 0, '0, eff);
      check_fwd("R2");
      check(rwp_busy == 1'b0, "R2", {31'd0, rwp_busy}, '0);

      // R8: restart of the busy count
      idle();
      bus_write(12'h188, 0, 0, 32'h00000001, eff);
      @(negedge clk);
      @(negedge clk);
      check(rwp_busy == 1'b1, "R8", {31'd0, rwp_busy}, 32'd1);
      bus_write(12'h188, 0, 0, 32'h00000002, eff);
      expect_busy_pulse("R8");
      check_fwd("R8");

      // R1: offsets outside the clear words and misaligned offsets
      idle();
      set_write(1, 0, 0, '1);
      bus_write(12'h100, 0, 0, '1, eff);
      bus_write(12'h186, 0, 0, '1, eff);
      check_fwd("R1");
      check(rwp_busy == 1'b0, "R1", {31'd0, rwp_busy}, '0);
      bus_read(12'h100, 0, 0, "R1");
      bus_read(12'h186, 0, 0, "R1");
      bus_read(12'h184, 0, 0, "R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule